// File: doc/BRIEF.md
# Timer Channel Counter Clock Controller

This block decides, cycle by cycle, whether the counter of one timer channel advances. It selects one clock source out of five internal timer clocks (synchronous level inputs) and three external clock inputs, and can invert the selected level. It can also gate the level with one of the external inputs acting as a burst window. Every rising edge of the resulting level, seen in the system clock domain, becomes a one-cycle count tick. A tick is only issued while the channel is both enabled and running.

Two stacked controls govern the channel. The enable layer is set by a software enable command. It is cleared by a software disable command, or by a mode-dependent automatic event: a B-register load in capture mode, or a C-register compare in waveform mode. The run layer is set by any trigger (software, sync, external or compare) and cleared by the matching mode-dependent stop event. The run layer only reacts while the enable layer is set. The three controller states are OFF (disabled), ARMED (enabled, stopped) and RUN (enabled, running). The transitions are T_ENABLE (OFF to ARMED), T_START (ARMED to RUN), T_STOP (RUN to ARMED) and T_DISABLE (ARMED or RUN to OFF). Every other case holds the state.

Top module: `tcc_clk_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the block starts in OFF: `clk_enabled`, `clk_running` and `cnt_tick` are all 0. The source select has no reset value of its own; encoding 0 selects internal clock 0.
- R2: `src_sel` values 0 to 4 select `int_clk[0]` to `int_clk[4]`. Values 5, 6 and 7 select `ext_clk[0]`, `ext_clk[1]` and `ext_clk[2]`. External inputs pass through a two-flop synchronizer first. Edges on unselected sources produce no tick.
- R3: With `clk_inv` = 1 the selected source is inverted, so ticks follow its falling edges instead of its rising edges.
- R4: `burst_sel` = 0 applies no gating. `burst_sel` = 1, 2 or 3 ANDs the (possibly inverted) source with the synchronized `ext_clk[0]`, `ext_clk[1]` or `ext_clk[2]`. While the gate is low, no tick is issued.
- R5: A command write (`cmd_wr` = 1) with `cmd_en` = 1 sets the enable layer. One with `cmd_dis` = 1 clears it. If both are set in the same write, disable wins. `clk_enabled` shows the enable layer one cycle after the write.
- R6: With `wave_mode` = 0 and `ldb_dis` = 1, an `rb_load` pulse clears the enable layer. With `wave_mode` = 1 and `cpc_dis` = 1, an `rc_cmp` pulse clears it. An event outside its own mode has no effect.
- R7: Any trigger (`cmd_swtrg` in a command write, `sync_trg`, `ext_trg`, `cmp_trg`) sets the run layer, but only if the enable layer was already set before that cycle. A trigger in the same write as `cmd_en` is ignored.
- R8: With `wave_mode` = 0 and `ldb_stop` = 1, an `rb_load` pulse clears the run layer. With `wave_mode` = 1 and `cpc_stop` = 1, an `rc_cmp` pulse clears it. In both cases the enable layer stays set.
- R9: Whenever the enable layer is cleared, the run layer is cleared with it. Re-enabling leaves the run layer clear.
- R10: `cnt_tick` is a single-cycle pulse. It is issued one cycle after the controller, being in RUN, samples a rising edge of the gated source level. It is never issued outside RUN.
- R11: Priority in one cycle is disable first, then trigger, then stop. A trigger together with a stop event leaves the channel running. A disable event together with a trigger leaves it OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_clk | input | 5 | Internal timer clock levels, synchronous to clk |
| ext_clk | input | 3 | External clock inputs, asynchronous |
| src_sel | input | 3 | Clock source select (0-4 internal, 5-7 external) |
| clk_inv | input | 1 | Invert the selected source |
| burst_sel | input | 2 | Burst gate select (0 none, 1-3 external input 0-2) |
| wave_mode | input | 1 | 0 capture mode, 1 waveform mode |
| ldb_dis | input | 1 | Capture mode: B-load event disables the clock |
| ldb_stop | input | 1 | Capture mode: B-load event stops the clock |
| cpc_dis | input | 1 | Waveform mode: C-compare event disables the clock |
| cpc_stop | input | 1 | Waveform mode: C-compare event stops the clock |
| cmd_wr | input | 1 | Command write strobe |
| cmd_en | input | 1 | Command: enable clock |
| cmd_dis | input | 1 | Command: disable clock |
| cmd_swtrg | input | 1 | Command: software trigger |
| rb_load | input | 1 | B-register load event pulse |
| rc_cmp | input | 1 | C-register compare event pulse |
| sync_trg | input | 1 | Sync trigger pulse |
| ext_trg | input | 1 | External trigger pulse |
| cmp_trg | input | 1 | Compare trigger pulse |
| cnt_tick | output | 1 | One-cycle count enable |
| clk_enabled | output | 1 | Enable layer status |
| clk_running | output | 1 | Run layer status |

## Verification
The assertions check several rules on every cycle. Running always implies enabled, and a tick always follows a cycle in RUN and lasts one cycle. Each disable command or in-mode disable event empties the enable layer. An enable command fills it. Triggers and stop events move the run layer as their priority demands. The bench scenarios show the edge selection: which source index and which external input a given encoding picks, and whether inversion and burst gating count exactly the expected edges through the synchronizer delay. These rules involve counting edges over a window of toggles, so only the scenarios can show them.

// File: rtl/tcc_clk_pkg.sv
`timescale 1ns/1ps
package tcc_clk_pkg;

    // Controller states: enable layer and run layer folded into one encoding
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } ctl_state_t;

    // Decoded requests for the controller
    typedef struct packed {
        logic en_req;
        logic dis_req;
        logic trg_req;
        logic stop_req;
    } ctl_req_t;

endpackage

// File: rtl/tcc_sync.sv
`timescale 1ns/1ps
module tcc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/tcc_src_path.sv
`timescale 1ns/1ps
module tcc_src_path #(
    parameter int N_INT       = 5,
    parameter int N_EXT       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = 3,
    parameter int BST_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_INT-1:0] int_clk,
    input  logic [N_EXT-1:0] ext_clk,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             clk_inv,
    input  logic [BST_W-1:0] burst_sel,
    output logic             src_rise
);
    localparam int N_SRC = N_INT + N_EXT;

    logic [N_EXT-1:0] ext_s;
    logic [N_SRC-1:0] src_vec;
    logic             sel_lvl;
    logic             gate_lvl;
    logic             gated_lvl;
    logic             gated_prev_q;

    // One synchronizer per external input
    for (genvar g = 0; g < N_EXT; g++) begin : g_xsync
        tcc_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (ext_clk[g]),
            .q_sync  (ext_s[g])
        );
    end

    assign src_vec = {ext_s, int_clk};

    // Source multiplexer
    always_comb begin
        sel_lvl = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (src_sel == SEL_W'(i)) sel_lvl = src_vec[i];
        end
    end

    // Burst gate: code 0 passes, code k gates with external input k-1
    always_comb begin
        gate_lvl = 1'b1;
        for (int i = 0; i < N_EXT; i++) begin
            if (burst_sel == BST_W'(i + 1)) gate_lvl = ext_s[i];
        end
    end

    assign gated_lvl = (sel_lvl ^ clk_inv) & gate_lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gated_prev_q <= 1'b0;
        end else begin
            gated_prev_q <= gated_lvl;
        end
    end

    assign src_rise = gated_lvl & ~gated_prev_q;
endmodule

// File: rtl/tcc_evt_decode.sv
`timescale 1ns/1ps
module tcc_evt_decode
    import tcc_clk_pkg::*;
(
    input  logic     wave_mode,
    input  logic     ldb_dis,
    input  logic     ldb_stop,
    input  logic     cpc_dis,
    input  logic     cpc_stop,
    input  logic     cmd_wr,
    input  logic     cmd_en,
    input  logic     cmd_dis,
    input  logic     cmd_swtrg,
    input  logic     rb_load,
    input  logic     rc_cmp,
    input  logic     sync_trg,
    input  logic     ext_trg,
    input  logic     cmp_trg,
    output ctl_req_t req
);
    logic cap_evt;
    logic wav_evt;

    // Each event only counts in its own mode
    assign cap_evt = ~wave_mode & rb_load;
    assign wav_evt =  wave_mode & rc_cmp;

    always_comb begin
        req.dis_req  = (cmd_wr & cmd_dis)
                     | (cap_evt & ldb_dis)
                     | (wav_evt & cpc_dis);
        req.en_req   = cmd_wr & cmd_en & ~cmd_dis;
        req.trg_req  = (cmd_wr & cmd_swtrg) | sync_trg | ext_trg | cmp_trg;
        req.stop_req = (cap_evt & ldb_stop) | (wav_evt & cpc_stop);
    end
endmodule

// File: rtl/tcc_ctl_fsm.sv
`timescale 1ns/1ps
module tcc_ctl_fsm
    import tcc_clk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  ctl_req_t req,
    input  logic     src_rise,
    output logic     cnt_tick,
    output logic     clk_enabled,
    output logic     clk_running
);
    ctl_state_t state_q;
    ctl_state_t state_d;
    logic       tick_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: T_ENABLE, T_START, T_STOP, T_DISABLE; all else holds
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (req.en_req) state_d = ST_ARMED;            // T_ENABLE
            end
            ST_ARMED: begin
                if (req.dis_req)       state_d = ST_OFF;       // T_DISABLE
                else if (req.trg_req)  state_d = ST_RUN;       // T_START
            end
            ST_RUN: begin
                if (req.dis_req)       state_d = ST_OFF;       // T_DISABLE
                else if (req.trg_req)  state_d = ST_RUN;       // trigger beats stop
                else if (req.stop_req) state_d = ST_ARMED;     // T_STOP
            end
            default: state_d = ST_OFF;
        endcase
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= 1'b0;
        end else begin
            tick_q <= (state_q == ST_RUN) & src_rise;
        end
    end

    assign cnt_tick    = tick_q;
    assign clk_enabled = (state_q != ST_OFF);
    assign clk_running = (state_q == ST_RUN);
endmodule

// File: rtl/tcc_clk_ctrl.sv
`timescale 1ns/1ps
module tcc_clk_ctrl
    import tcc_clk_pkg::*;
#(
    parameter  int N_INT       = 5,
    parameter  int N_EXT       = 3,
    parameter  int SYNC_STAGES = 2,
    localparam int SEL_W       = $clog2(N_INT + N_EXT),
    localparam int BST_W       = $clog2(N_EXT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_INT-1:0] int_clk,
    input  logic [N_EXT-1:0] ext_clk,
    input  logic [SEL_W-1:0] src_sel,
    input  logic             clk_inv,
    input  logic [BST_W-1:0] burst_sel,
    input  logic             wave_mode,
    input  logic             ldb_dis,
    input  logic             ldb_stop,
    input  logic             cpc_dis,
    input  logic             cpc_stop,
    input  logic             cmd_wr,
    input  logic             cmd_en,
    input  logic             cmd_dis,
    input  logic             cmd_swtrg,
    input  logic             rb_load,
    input  logic             rc_cmp,
    input  logic             sync_trg,
    input  logic             ext_trg,
    input  logic             cmp_trg,
    output logic             cnt_tick,
    output logic             clk_enabled,
    output logic             clk_running
);
    ctl_req_t req;
    logic     src_rise;

    tcc_src_path #(
        .N_INT       (N_INT),
        .N_EXT       (N_EXT),
        .SYNC_STAGES (SYNC_STAGES),
        .SEL_W       (SEL_W),
        .BST_W       (BST_W)
    ) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .int_clk   (int_clk),
        .ext_clk   (ext_clk),
        .src_sel   (src_sel),
        .clk_inv   (clk_inv),
        .burst_sel (burst_sel),
        .src_rise  (src_rise)
    );

    tcc_evt_decode u_dec (
        .wave_mode (wave_mode),
        .ldb_dis   (ldb_dis),
        .ldb_stop  (ldb_stop),
        .cpc_dis   (cpc_dis),
        .cpc_stop  (cpc_stop),
        .cmd_wr    (cmd_wr),
        .cmd_en    (cmd_en),
        .cmd_dis   (cmd_dis),
        .cmd_swtrg (cmd_swtrg),
        .rb_load   (rb_load),
        .rc_cmp    (rc_cmp),
        .sync_trg  (sync_trg),
        .ext_trg   (ext_trg),
        .cmp_trg   (cmp_trg),
        .req       (req)
    );

    tcc_ctl_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .src_rise    (src_rise),
        .cnt_tick    (cnt_tick),
        .clk_enabled (clk_enabled),
        .clk_running (clk_running)
    );
endmodule

// File: rtl/tcc_clk_ctrl_chk.sv
`timescale 1ns/1ps
module tcc_clk_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic wave_mode,
    input logic ldb_dis,
    input logic ldb_stop,
    input logic cpc_dis,
    input logic cpc_stop,
    input logic cmd_wr,
    input logic cmd_en,
    input logic cmd_dis,
    input logic cmd_swtrg,
    input logic rb_load,
    input logic rc_cmp,
    input logic sync_trg,
    input logic ext_trg,
    input logic cmp_trg,
    input logic cnt_tick,
    input logic clk_enabled,
    input logic clk_running
);
    logic any_trg;
    logic any_dis;
    logic any_stop;

    assign any_trg  = (cmd_wr & cmd_swtrg) | sync_trg | ext_trg | cmp_trg;
    assign any_dis  = (cmd_wr & cmd_dis) | (~wave_mode & ldb_dis & rb_load)
                    | (wave_mode & cpc_dis & rc_cmp);
    assign any_stop = (~wave_mode & ldb_stop & rb_load) | (wave_mode & cpc_stop & rc_cmp);

    AST_RUN_IMPLIES_EN: assert property (@(posedge clk) disable iff (!rst_n)
        clk_running |-> clk_enabled);                                            // R9
    AST_EN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_en && !cmd_dis) |=> clk_enabled);                         // R5
    AST_DIS_CMD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && cmd_dis) |=> (!clk_enabled && !clk_running));                 // R5
    AST_CAP_AUTO_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wave_mode && ldb_dis && rb_load) |=> !clk_enabled);                    // R6
    AST_WAV_AUTO_DIS: assert property (@(posedge clk) disable iff (!rst_n)
        (wave_mode && cpc_dis && rc_cmp) |=> !clk_enabled);                      // R6
    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_enabled |=> !clk_running);                                          // R7
    AST_TRG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_enabled && any_trg && !any_dis) |=> clk_running);                   // R11
    AST_STOP_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_enabled && any_stop && !any_trg && !any_dis) |=> (clk_enabled && !clk_running)); // R8
    AST_TICK_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_tick |-> $past(clk_running));                                        // R10
    AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_tick |=> !cnt_tick);                                                 // R10
endmodule

bind tcc_clk_ctrl tcc_clk_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wave_mode   (wave_mode),
    .ldb_dis     (ldb_dis),
    .ldb_stop    (ldb_stop),
    .cpc_dis     (cpc_dis),
    .cpc_stop    (cpc_stop),
    .cmd_wr      (cmd_wr),
    .cmd_en      (cmd_en),
    .cmd_dis     (cmd_dis),
    .cmd_swtrg   (cmd_swtrg),
    .rb_load     (rb_load),
    .rc_cmp      (rc_cmp),
    .sync_trg    (sync_trg),
    .ext_trg     (ext_trg),
    .cmp_trg     (cmp_trg),
    .cnt_tick    (cnt_tick),
    .clk_enabled (clk_enabled),
    .clk_running (clk_running)
);

// File: tb/tcc_clk_ctrl_test.sv
`timescale 1ns/1ps
module tcc_clk_ctrl_test;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic [4:0] int_clk = '0;
    logic [2:0] ext_clk = '0;
    logic [2:0] src_sel = '0;
    logic       clk_inv = 1'b0;
    logic [1:0] burst_sel = '0;
    logic wave_mode = 0, ldb_dis = 0, ldb_stop = 0, cpc_dis = 0, cpc_stop = 0;
    logic cmd_wr = 0, cmd_en = 0, cmd_dis = 0, cmd_swtrg = 0;
    logic rb_load = 0, rc_cmp = 0, sync_trg = 0, ext_trg = 0, cmp_trg = 0;
    logic cnt_tick, clk_enabled, clk_running;

    tcc_clk_ctrl uut (
        .clk(clk), .rst_n(rst_n), .int_clk(int_clk), .ext_clk(ext_clk),
        .src_sel(src_sel), .clk_inv(clk_inv), .burst_sel(burst_sel),
        .wave_mode(wave_mode), .ldb_dis(ldb_dis), .ldb_stop(ldb_stop),
        .cpc_dis(cpc_dis), .cpc_stop(cpc_stop), .cmd_wr(cmd_wr),
        .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_swtrg(cmd_swtrg),
        .rb_load(rb_load), .rc_cmp(rc_cmp), .sync_trg(sync_trg),
        .ext_trg(ext_trg), .cmp_trg(cmp_trg), .cnt_tick(cnt_tick),
        .clk_enabled(clk_enabled), .clk_running(clk_running)
    );

    int n_chk = 0;
    int n_err = 0;
    int tick_cnt = 0;
    bit done = 0;

    task automatic check(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge
    bit       m_en, m_run, m_prev, m_tick;
    bit [2:0] m_s1, m_s2;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_run = 0; m_prev = 0; m_tick = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            bit lvl, dis, trg, stp;
            int s;
            s   = int'(src_sel);
            lvl = (s < 5) ? int_clk[s] : m_s2[s-5];
            lvl = lvl ^ clk_inv;
            if (burst_sel != 0) lvl = lvl & m_s2[int'(burst_sel) - 1];
            m_tick = m_run && lvl && !m_prev;
            m_prev = lvl;
            m_s2 = m_s1;
            m_s1 = ext_clk;
            dis = (cmd_wr && cmd_dis) || (!wave_mode && ldb_dis && rb_load)
                || (wave_mode && cpc_dis && rc_cmp);
            trg = (cmd_wr && cmd_swtrg) || sync_trg || ext_trg || cmp_trg;
            stp = (!wave_mode && ldb_stop && rb_load) || (wave_mode && cpc_stop && rc_cmp);
            if (!m_en) begin
                if (cmd_wr && cmd_en && !cmd_dis) m_en = 1;
            end else if (dis) begin
                m_en = 0; m_run = 0;
            end else if (trg) begin
                m_run = 1;
            end else if (stp) begin
                m_run = 0;
            end
        end
    end

    // Per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(cnt_tick == m_tick, "R10 tick vs model", cnt_tick, m_tick);
            check(clk_enabled == m_en, "R5 enable vs model", clk_enabled, m_en);
            check(clk_running == m_run, "R7 run vs model", clk_running, m_run);
        end
        if (cnt_tick) tick_cnt++;
    end

    task automatic cyc(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic cmd(bit en, bit dis, bit swt);
        cmd_wr = 1; cmd_en = en; cmd_dis = dis; cmd_swtrg = swt;
        cyc();
        cmd_wr = 0; cmd_en = 0; cmd_dis = 0; cmd_swtrg = 0;
    endtask

    task automatic pulse_rb(); rb_load = 1; cyc(); rb_load = 0; endtask
    task automatic pulse_rc(); rc_cmp = 1; cyc(); rc_cmp = 0; endtask
    task automatic pulse_sync(); sync_trg = 1; cyc(); sync_trg = 0; endtask
    task automatic pulse_ext(); ext_trg = 1; cyc(); ext_trg = 0; endtask

    task automatic state_is(bit e, bit r, string tag);
        check(clk_enabled == e, {tag, " enabled"}, clk_enabled, e);
        check(clk_running == r, {tag, " running"}, clk_running, r);
    endtask

    // Toggle one source n full periods, then let the pipeline drain
    task automatic toggle(bit is_ext, int idx, int n);
        for (int k = 0; k < n; k++) begin
            if (is_ext) ext_clk[idx] = 1; else int_clk[idx] = 1;
            cyc(2);
            if (is_ext) ext_clk[idx] = 0; else int_clk[idx] = 0;
            cyc(2);
        end
        cyc(4);
    endtask

    task automatic count_ticks(bit is_ext, int idx, int n, int exp, string tag);
        cyc(4);
        tick_cnt = 0;
        toggle(is_ext, idx, n);
        check(tick_cnt == exp, tag, tick_cnt, exp);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        cyc(3);
        check(!clk_enabled && !clk_running && !cnt_tick, "R1 reset state", clk_enabled, 0);
        rst_n = 1;
        cyc(2);
        state_is(0, 0, "R1 after reset");

        pulse_sync();
        state_is(0, 0, "R7 trigger while off");
        cmd(1, 1, 0);
        state_is(0, 0, "R5 en+dis same write");
        cmd(1, 0, 1);
        state_is(1, 0, "R7 trigger with enable");
        pulse_sync();
        state_is(1, 1, "R7 sync trigger starts");

        src_sel = 3'd2;
        count_ticks(0, 2, 3, 3, "R2 internal clock 2 ticks");
        count_ticks(0, 1, 3, 0, "R2 unselected internal clock");
        src_sel = 3'd6;
        count_ticks(1, 1, 4, 4, "R2 external clock 1 ticks");
        count_ticks(1, 0, 2, 0, "R2 unselected external clock");

        src_sel = 3'd0; clk_inv = 1;
        count_ticks(0, 0, 3, 3, "R3 inverted clock ticks");
        clk_inv = 0;

        src_sel = 3'd3; burst_sel = 2'd1;
        count_ticks(0, 3, 3, 0, "R4 burst gate low");
        ext_clk[0] = 1;
        count_ticks(0, 3, 3, 3, "R4 burst gate high");
        burst_sel = 2'd3;
        count_ticks(0, 3, 2, 0, "R4 burst ext2 low");
        burst_sel = 2'd0; ext_clk[0] = 0;
        cyc(4);

        wave_mode = 0; ldb_stop = 1;
        pulse_rb();
        state_is(1, 0, "R8 capture stop");
        count_ticks(0, 3, 2, 0, "R10 no tick when stopped");
        pulse_ext();
        state_is(1, 1, "R7 external trigger");
        wave_mode = 1;
        pulse_rb();
        state_is(1, 1, "R8 rb ignored in waveform");
        cpc_stop = 1;
        pulse_rc();
        state_is(1, 0, "R8 waveform stop");
        rc_cmp = 1; cmp_trg = 1; cyc(); rc_cmp = 0; cmp_trg = 0;
        state_is(1, 1, "R11 trigger beats stop");
        cpc_stop = 0; ldb_stop = 0;

        cpc_dis = 1;
        pulse_rc();
        state_is(0, 0, "R6 waveform auto disable");
        pulse_sync();
        state_is(0, 0, "R9 trigger after disable");
        cmd(1, 0, 0);
        state_is(1, 0, "R9 reenable stays stopped");
        cpc_dis = 0; pulse_sync();
        wave_mode = 0; ldb_dis = 1;
        pulse_rb();
        state_is(0, 0, "R6 capture auto disable");
        cmd(1, 0, 0); pulse_sync();
        wave_mode = 1;
        pulse_rb();
        state_is(1, 1, "R6 rb ignored in waveform");
        ldb_dis = 0;
        cmd(0, 1, 0);
        state_is(0, 0, "R5 disable command");
        cmd(1, 0, 0); pulse_sync();
        cmd_wr = 1; cmd_dis = 1; sync_trg = 1; cyc();
        cmd_wr = 0; cmd_dis = 0; sync_trg = 0;
        state_is(0, 0, "R11 disable beats trigger");
        cyc(3);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule